// File: doc/BRIEF.md
# UART Receiver with Flagged Two-Entry Buffer

This block is the receive half of a UART. It watches an asynchronous serial line and turns each frame into a data byte. A frame is a low start bit, 8 data bits sent least significant bit first, an optional parity bit and a stop bit. Every bit is sampled once, in the middle of the bit, using a tick input that runs at sixteen times the bit rate. Each finished frame goes into a two-entry receive buffer. The byte is stored together with its own frame-error flag and parity-error flag, so the flags always describe the byte they arrived with.

Software first reads the status of the entry at the head of the buffer and then pops the data byte. A receive-complete output is high while any entry is still unread. A level interrupt request follows receive-complete, gated by a receive interrupt enable and a global interrupt enable.

When both entries are full and another frame completes, the block raises an overrun flag. It then drops every new frame until the buffer is read. Clearing the receiver enable stops reception at once and empties the buffer, including all stored entries and flags.

Top module: `uart_rx_flagbuf`

## Requirements
- R1: After reset, `rxc`, `irq` and `rd_ovr` are 0, and `rd_data`, `rd_ferr` and `rd_perr` are all zero. The head outputs also read zero whenever the buffer is empty.
- R2: A frame is a low start bit, 8 data bits LSB first, an optional parity bit and one stop bit, each bit 16 ticks of `tick16` long. A completed frame appears on `rd_data` with `rxc` high.
- R3: The buffer holds two frames in arrival order. `rd_ferr` and `rd_perr` show the flags stored with the byte currently at the head. A pulse on `rd_pop` advances the buffer to the next entry.
- R4: `rxc` is 1 while the buffer holds at least one unread entry and 0 when it is empty.
- R5: `irq` is 1 exactly when `rxc`, `rxc_ie` and `glb_ie` are all 1.
- R6: `rd_ferr` is 1 when the stop bit was sampled as 0, and 0 when it was sampled as 1.
- R7: With `par_en`=1, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. `rd_perr` is 1 when the received parity bit does not match. With `par_en`=0, no parity bit is expected and `rd_perr` is always 0.
- R8: A frame that completes while the buffer holds two entries and no pop occurs in that cycle is dropped and sets `rd_ovr`. While `rd_ovr` is 1, every completed frame is dropped.
- R9: A pop clears `rd_ovr`, and the frames that complete after it are stored again.
- R10: A frame that completes in the same cycle as a pop from a full buffer, with `rd_ovr` at 0, is stored and does not set `rd_ovr`.
- R11: A start bit that is high again at its mid-bit sample is rejected, and nothing is stored.
- R12: `rx_en`=0 empties the buffer, clears `rd_ovr` and `rxc` by the next cycle, and stops reception. A frame sent while `rx_en` is 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receiver enable; 0 flushes the buffer and halts reception |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| rxc_ie | input | 1 | Receive interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| rd_pop | input | 1 | Pulse: remove the head entry |
| rd_data | output | 8 | Data byte at the head of the buffer (0 when empty) |
| rd_ferr | output | 1 | Frame-error flag of the head entry |
| rd_perr | output | 1 | Parity-error flag of the head entry |
| rd_ovr | output | 1 | Overrun flag |
| rxc | output | 1 | Receive complete: the buffer is not empty |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sweeps a pop across the whole stop bit of a third frame arriving at a full buffer. One of these pops lands in the cycle where the frame completes. A design that treats that cycle as an overrun leaves `rd_ovr` set after the pop, and a design that drops the frame loses the early-pop case. The bench sends frames with a bad stop bit and with corrupted parity under both parities, and then pops them one at a time. A design that kept one shared flag register would report the flags of the wrong byte. Further directed cases cover a glitch shorter than half a bit, a fourth frame during overrun that must not replace the second entry, and frames sent while the receiver is disabled; a wrong design would store a phantom byte or keep stale entries after the flush.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic ferr;
    logic perr;
  } rx_flags_t;

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output rx_flags_t         flags
);

  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_t          state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   nbit;
  logic [DATA_W-1:0]  shreg;
  logic               pbit;
  logic               rx_meta, rx_sync;

  // two-stage synchronizer for the asynchronous line
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rx_sync <= rx_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      flags <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!rx_sync) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (!rx_sync) begin
                state <= ST_DATA;
                nbit  <= '0;
              end else begin
                state <= ST_IDLE;       // glitch: reject
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == LAST_CNT) begin
              cnt   <= '0;
              shreg <= {rx_sync, shreg[DATA_W-1:1]};
              if (nbit == LAST_BIT) state <= par_en ? ST_PAR : ST_STOP;
              else                  nbit  <= nbit + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == LAST_CNT) begin
              cnt   <= '0;
              pbit  <= rx_sync;
              state <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == LAST_CNT) begin
              cnt        <= '0;
              state      <= ST_IDLE;
              done       <= 1'b1;
              data       <= shreg;
              flags.ferr <= !rx_sync;
              flags.perr <= par_en && ((^shreg ^ pbit) != par_odd);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: a completed frame is reported for a single cycle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12: a disabled receiver leaves the frame machine idle and reports nothing
  assert_off_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == ST_IDLE && !done));

  // R11: a start bit that is high at mid-bit goes back to idle
  assert_false_start_R11: assert property (@(posedge clk) disable iff (rst)
    (en && tick && state == ST_START && cnt == MID_CNT && rx_sync) |=> state == ST_IDLE);

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  rx_flags_t         wr_flags,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] head_data,
  output rx_flags_t         head_flags,
  output logic              not_empty,
  output logic              ovr
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem_d [DEPTH];
  rx_flags_t         mem_f [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level;
  logic              full, do_pop, do_push, ovr_set;

  assign full    = (level == FULL_LVL);
  assign do_pop  = rd_pop && (level != '0);
  assign do_push = wr_valid && !ovr && (!full || do_pop);
  assign ovr_set = wr_valid && !ovr && full && !do_pop;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovr    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_d[i] <= '0;
        mem_f[i] <= '0;
      end
    end else begin
      if (do_push) begin
        mem_d[wr_ptr] <= wr_data;
        mem_f[wr_ptr] <= wr_flags;
        wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
      if (do_pop)       ovr <= 1'b0;
      else if (ovr_set) ovr <= 1'b1;
    end
  end

  assign not_empty  = (level != '0);
  assign head_data  = not_empty ? mem_d[rd_ptr] : '0;
  assign head_flags = not_empty ? mem_f[rd_ptr] : '0;

  // R3: occupancy never exceeds the two slots
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  // R8: a frame into a full buffer without a pop raises overrun
  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (rst)
    (!flush && wr_valid && full && !rd_pop) |=> ovr);

  // R8: during overrun, nothing is stored
  assert_ovr_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (!flush && ovr && !rd_pop) |=> $stable(level));

  // R9: a pop clears overrun
  assert_pop_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (ovr && rd_pop) |=> !ovr);

  // R10: frame and pop in the same cycle at full keep the buffer full, no overrun
  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (!flush && wr_valid && full && rd_pop && !ovr) |=> (full && !ovr));

  // R12: flush empties the buffer and clears overrun
  assert_flush_R12: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0 && !ovr));

endmodule

// File: rtl/uart_rx_flagbuf.sv
module uart_rx_flagbuf
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxc_ie,
  input  logic              glb_ie,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              rd_perr,
  output logic              rd_ovr,
  output logic              rxc,
  output logic              irq
);

  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  rx_flags_t         fr_flags;
  rx_flags_t         hd_flags;
  logic              nonempty;

  uart_rx_deser #(.DATA_W(DATA_W), .OSR(OSR)) u_deser (
    .clk     (clk),
    .rst     (rst),
    .en      (rx_en),
    .tick    (tick16),
    .rxd     (rxd),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (fr_done),
    .data    (fr_data),
    .flags   (fr_flags)
  );

  uart_rx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .flush      (!rx_en),
    .wr_valid   (fr_done),
    .wr_data    (fr_data),
    .wr_flags   (fr_flags),
    .rd_pop     (rd_pop),
    .head_data  (rd_data),
    .head_flags (hd_flags),
    .not_empty  (nonempty),
    .ovr        (rd_ovr)
  );

  assign rd_ferr = hd_flags.ferr;
  assign rd_perr = hd_flags.perr;
  assign rxc     = nonempty;
  assign irq     = nonempty && rxc_ie && glb_ie;

  // R12: the disable reaches the status outputs one cycle later
  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rxc && !rd_ovr));

  // R4: receive-complete can only rise as the result of a finished frame
  assert_rxc_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rxc) |-> $past(fr_done));

endmodule

// File: tb/uart_rx_flagbuf_bench.sv
module uart_rx_flagbuf_bench;

  localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] tdiv = '0;
  logic       tick16;
  logic       rxd = 1'b1, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic       rxc_ie = 1'b0, glb_ie = 1'b0, rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rd_ferr, rd_perr, rd_ovr, rxc, irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    cyc  <= cyc + 1;
  end
  assign tick16 = (tdiv == 2'd3);

  uart_rx_flagbuf u_uart_rx_flagbuf (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .par_en(par_en), .par_odd(par_odd), .rxc_ie(rxc_ie), .glb_ie(glb_ie),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
    .rd_ovr(rd_ovr), .rxc(rxc), .irq(irq)
  );

  // {data, par_en, par_odd, corrupt_parity, bad_stop, exp_ferr, exp_perr}
  localparam logic [13:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h07, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h07, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Sends one frame; the parity bit is included only when pe is set.
  task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                            input logic corrupt, input logic bad_stop);
    @(posedge clk); #1;
    rxd = 1'b0;
    wait_clk(BIT_CLK);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      wait_clk(BIT_CLK);
    end
    if (pe) begin
      rxd = (^d) ^ po ^ corrupt;
      wait_clk(BIT_CLK);
    end
    if (bad_stop) begin
      rxd = 1'b0;
      wait_clk(44);
      rxd = 1'b1;
      wait_clk(BIT_CLK - 44);
    end else begin
      rxd = 1'b1;
      wait_clk(BIT_CLK);
    end
    wait_clk(BIT_CLK);   // idle gap
  endtask

  task automatic pop_once();
    @(posedge clk); #1;
    rd_pop = 1'b1;
    @(posedge clk); #1;
    rd_pop = 1'b0;
  endtask

  task automatic disable_rx();
    @(posedge clk); #1;
    rx_en = 1'b0;
    wait_clk(2);
    rx_en = 1'b1;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (!finished && cyc >= 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    // R1 reset state
    chk("R1 rxc", rxc, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovr", rd_ovr, 0);
    chk("R1 data/flags", {rd_data, rd_ferr, rd_perr}, 0);
    rx_en = 1'b1;
    wait_clk(8);

    // R2, R6, R7: vector table
    foreach (VEC[i]) begin
      par_en  = VEC[i][5];
      par_odd = VEC[i][4];
      send_frame(VEC[i][13:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk("R4 rxc after frame", rxc, 1);
      chk("R2 data", rd_data, VEC[i][13:6]);
      chk("R6 ferr", rd_ferr, VEC[i][1]);
      chk("R7 perr", rd_perr, VEC[i][0]);
      pop_once();
      chk("R4 rxc after pop", rxc, 0);
      chk("R1 empty head", {rd_data, rd_ferr, rd_perr}, 0);
    end
    par_en = 1'b0;
    par_odd = 1'b0;

    // R3: flags travel with their byte
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 head data first", rd_data, 8'h5A);
    chk("R3 head ferr first", rd_ferr, 1);
    pop_once();
    chk("R3 head data second", rd_data, 8'hC3);
    chk("R3 head ferr second", rd_ferr, 0);
    chk("R4 rxc one left", rxc, 1);

    // R5: interrupt gating
    rxc_ie = 1'b0; glb_ie = 1'b1; wait_clk(1);
    chk("R5 irq ie off", irq, 0);
    rxc_ie = 1'b1; glb_ie = 1'b0; wait_clk(1);
    chk("R5 irq gie off", irq, 0);
    glb_ie = 1'b1; wait_clk(1);
    chk("R5 irq both on", irq, 1);
    pop_once();
    chk("R5 irq empty", irq, 0);
    rxc_ie = 1'b0; glb_ie = 1'b0;

    // R8, R9: overrun
    send_frame(8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(8'h02, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 no ovr at full", rd_ovr, 0);
    send_frame(8'h03, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 ovr set", rd_ovr, 1);
    send_frame(8'h04, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 head kept", rd_data, 8'h01);
    pop_once();
    chk("R9 ovr cleared", rd_ovr, 0);
    chk("R8 dropped frames", rd_data, 8'h02);
    pop_once();
    chk("R8 empty after two", rxc, 0);
    send_frame(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 accepts again", rd_data, 8'h77);
    pop_once();

    // R11: short glitch
    @(posedge clk); #1;
    rxd = 1'b0;
    wait_clk(16);
    rxd = 1'b1;
    wait_clk(4 * BIT_CLK);
    chk("R11 glitch stores nothing", rxc, 0);

    // R12: flush and disabled reception
    send_frame(8'h10, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(8'h20, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(8'h30, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    rx_en = 1'b0;
    wait_clk(1);
    chk("R12 rxc flushed", rxc, 0);
    chk("R12 ovr flushed", rd_ovr, 0);
    chk("R12 head cleared", {rd_data, rd_ferr, rd_perr}, 0);
    send_frame(8'h44, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 no reception when off", rxc, 0);
    rx_en = 1'b1;
    wait_clk(4);
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 resumes", rd_data, 8'h55);
    disable_rx();

    // R10: pop swept across the stop bit of a frame arriving at a full buffer
    for (int k = 20; k <= 52; k++) begin
      disable_rx();
      wait_clk(4);
      send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
      send_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
      fork
        send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
        begin
          repeat (9 * BIT_CLK + k + 1) @(posedge clk);
          #1 rd_pop = 1'b1;
          @(posedge clk);
          #1 rd_pop = 1'b0;
        end
      join
      chk("R10 no ovr left after pop", rd_ovr, 0);
      chk("R10 head is second frame", rd_data, 8'h22);
      if (k == 20) begin
        pop_once();
        chk("R10 early pop keeps frame", rd_data, 8'h33);
      end
      if (k == 52) begin
        pop_once();
        chk("R8 late pop frame lost", rxc, 0);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule